// File: doc/BRIEF.md
# Diagnostic Evidence Accumulator and Ranker

This block scores a set of candidate faults against the observed behaviour of a device under diagnosis. Each beat carries one test pattern's response from the device, the response of the fault machine for one addressed candidate, and the expected fault-free response. The block forms two difference vectors: device against expected, and fault machine against expected. From these it derives three per-pattern counts for the addressed candidate. Predictions are outputs that fail in both. Mispredictions are outputs that fail only in the fault machine. Unexplained fails are outputs that fail only in the device. A conflict term is also derived: the smaller of predictions and mispredictions. All four are added into that candidate's running totals, which saturate at their width.

When the beat marked last has been taken in, the block orders the candidates by a three-key rule using a sequential insertion sort. It then raises a done flag that stays high until reset. The ranked list and the four totals of every candidate are visible on the ports at all times. The fault simulation that produces the fault machine responses is done elsewhere and feeds this block.

Top module: `evid_rank`

## Requirements
- R1: On an accepted beat where the fault machine differs from expected, the addressed candidate's prediction total grows by the popcount of (device XOR expected) AND (fault XOR expected), visible one clock after the beat.
- R2: In the same case the misprediction total grows by the popcount of the fault difference AND NOT the device difference.
- R3: In the same case the unexplained total grows by the popcount of the device difference AND NOT the fault difference.
- R4: In the same case the conflict total grows by the minimum of that beat's prediction and misprediction counts, so it never exceeds either total.
- R5: A beat whose fault machine response equals the expected response leaves all four totals of every candidate unchanged.
- R6: A beat whose device response equals the expected response can only raise the misprediction total; prediction, unexplained and conflict totals stay unchanged.
- R7: Each total holds at 2^CNT_W-1 instead of wrapping, and never decreases before reset.
- R8: When done, rank position 0 (lowest bits of `rank_list`, IW bits per position) holds the best candidate. Candidates are ordered by ascending conflict total, then descending prediction total, then ascending misprediction total.
- R9: Candidates equal in all three keys appear in ascending candidate index order.
- R10: `done` is low until the last-marked beat, rises after the insertion sort completes, stays high until reset, and the list is then a permutation of all candidate indices.
- R11: Beats presented after the last-marked beat has been accepted change neither the totals nor the ranked list.
- R12: After reset all totals are zero, `done` is low and `rank_list` holds the identity order (position p holds index p).
- R13: A beat updates only the candidate addressed by `cand_idx`; all other candidates keep their totals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_valid | input | 1 | A beat is presented this cycle |
| pat_last | input | 1 | With pat_valid: final beat, ranking starts afterwards |
| cand_idx | input | IW | Candidate whose fault machine response is on fm_resp |
| dev_resp | input | N_OUT | Response of the device under diagnosis |
| fm_resp | input | N_OUT | Response of the fault machine for cand_idx |
| exp_resp | input | N_OUT | Expected fault-free response |
| pred_tot | output | N_CAND*CNT_W | Prediction totals, candidate k at bits k*CNT_W |
| mis_tot | output | N_CAND*CNT_W | Misprediction totals |
| unx_tot | output | N_CAND*CNT_W | Unexplained-fail totals |
| cfl_tot | output | N_CAND*CNT_W | Conflict totals (sum of per-beat minima) |
| rank_list | output | N_CAND*IW | Ranked candidate indices, best at position 0 |
| done | output | 1 | Ranking complete, list valid |

## Verification
The bench sweeps every device difference pattern against every fault difference pattern, with a varying expected vector. This exposes a design that counts raw response bits instead of difference bits, that swaps the misprediction and unexplained terms, or that takes the maximum rather than the minimum for the conflict term. Beats with a silent fault machine and beats with a passing device catch a design that still charges unexplained fails or predictions in those cases. A long run of all-fail beats drives totals into saturation, where a wrapping counter would drop to a small value and reorder the ranking. Fully tied candidates fed in reverse index order catch an unstable sort. Beats sent after the last strobe catch a design that keeps accumulating or re-sorts.

// File: rtl/evid_pkg.sv
package evid_pkg;

  typedef enum logic [1:0] {
    PH_ACC  = 2'd0,
    PH_SORT = 2'd1,
    PH_FIN  = 2'd2
  } phase_e;

  // Number of set bits in a vector of up to 64 bits.
  function automatic int unsigned ones64(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int b = 0; b < 64; b++) begin
      n += {31'd0, v[b]};
    end
    return n;
  endfunction

  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  // Add with a ceiling instead of wrap-around.
  function automatic int unsigned add_cap(input int unsigned acc, input int unsigned inc,
                                          input int unsigned cap);
    int unsigned room;
    room = cap - acc;
    return (inc > room) ? cap : acc + inc;
  endfunction

  // True when tuple A must be placed strictly ahead of tuple B.
  // Keys: conflict ascending, prediction descending, misprediction ascending.
  function automatic logic ranks_ahead(input int unsigned ca, input int unsigned pa,
                                       input int unsigned ma, input int unsigned cb,
                                       input int unsigned pb, input int unsigned mb);
    if (ca != cb) return ca < cb;
    if (pa != pb) return pa > pb;
    return ma < mb;
  endfunction

endpackage

// File: rtl/evid_delta.sv
module evid_delta
  import evid_pkg::*;
#(
  parameter int N_OUT = 4,
  localparam int DW = $clog2(N_OUT + 1)
) (
  input  logic [N_OUT-1:0] dev_resp,
  input  logic [N_OUT-1:0] fm_resp,
  input  logic [N_OUT-1:0] exp_resp,
  output logic             observ,
  output logic             dev_fail,
  output logic [DW-1:0]    d_pred,
  output logic [DW-1:0]    d_mis,
  output logic [DW-1:0]    d_unx,
  output logic [DW-1:0]    d_cfl
);

  logic [N_OUT-1:0] dev_diff;
  logic [N_OUT-1:0] fm_diff;
  int unsigned      n_pred;
  int unsigned      n_mis;
  int unsigned      n_unx;

  assign dev_diff = dev_resp ^ exp_resp;
  assign fm_diff  = fm_resp ^ exp_resp;
  assign observ   = |fm_diff;
  assign dev_fail = |dev_diff;

  always_comb begin
    n_pred = ones64(64'(dev_diff & fm_diff));
    n_mis  = ones64(64'(fm_diff & ~dev_diff));
    n_unx  = ones64(64'(dev_diff & ~fm_diff));
  end

  assign d_pred = DW'(n_pred);
  assign d_mis  = DW'(n_mis);
  assign d_unx  = DW'(n_unx);
  assign d_cfl  = DW'(min_u(n_pred, n_mis));

endmodule

// File: rtl/evid_store.sv
module evid_store
  import evid_pkg::*;
#(
  parameter int N_OUT  = 4,
  parameter int N_CAND = 4,
  parameter int CNT_W  = 6,
  localparam int IW = (N_CAND > 1) ? $clog2(N_CAND) : 1,
  localparam int DW = $clog2(N_OUT + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             acc_en,
  input  logic                             observ,
  input  logic [IW-1:0]                    cand_idx,
  input  logic [DW-1:0]                    d_pred,
  input  logic [DW-1:0]                    d_mis,
  input  logic [DW-1:0]                    d_unx,
  input  logic [DW-1:0]                    d_cfl,
  output logic [N_CAND-1:0][CNT_W-1:0]     pred_q,
  output logic [N_CAND-1:0][CNT_W-1:0]     mis_q,
  output logic [N_CAND-1:0][CNT_W-1:0]     unx_q,
  output logic [N_CAND-1:0][CNT_W-1:0]     cfl_q
);

  localparam int unsigned CAP = (2 ** CNT_W) - 1;

  for (genvar k = 0; k < N_CAND; k++) begin : g_cand
    logic hit;
    assign hit = acc_en && observ && (int'(cand_idx) == k);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pred_q[k] <= '0;
        mis_q[k]  <= '0;
        unx_q[k]  <= '0;
        cfl_q[k]  <= '0;
      end else if (hit) begin
        pred_q[k] <= CNT_W'(add_cap(32'(pred_q[k]), 32'(d_pred), CAP));
        mis_q[k]  <= CNT_W'(add_cap(32'(mis_q[k]),  32'(d_mis),  CAP));
        unx_q[k]  <= CNT_W'(add_cap(32'(unx_q[k]),  32'(d_unx),  CAP));
        cfl_q[k]  <= CNT_W'(add_cap(32'(cfl_q[k]),  32'(d_cfl),  CAP));
      end
    end
  end

endmodule

// File: rtl/rank_sorter.sv
module rank_sorter
  import evid_pkg::*;
#(
  parameter int N_CAND = 4,
  parameter int CNT_W  = 6,
  localparam int IW = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [N_CAND-1:0][CNT_W-1:0] pred_q,
  input  logic [N_CAND-1:0][CNT_W-1:0] mis_q,
  input  logic [N_CAND-1:0][CNT_W-1:0] cfl_q,
  output logic [N_CAND-1:0][IW-1:0]    ord,
  output logic                         fin
);

  logic [IW:0]   outer;
  logic [IW-1:0] inner;
  logic [IW-1:0] inner_m1;
  logic          busy;
  logic          swap_now;
  logic [IW-1:0] id_hi;
  logic [IW-1:0] id_lo;

  assign inner_m1 = inner - 1'b1;
  assign id_hi    = ord[inner];
  assign id_lo    = ord[inner_m1];

  // The entry at inner moves down while it strictly beats its neighbour.
  assign swap_now = (inner != '0) &&
                    ranks_ahead(32'(cfl_q[id_hi]), 32'(pred_q[id_hi]), 32'(mis_q[id_hi]),
                                32'(cfl_q[id_lo]), 32'(pred_q[id_lo]), 32'(mis_q[id_lo]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N_CAND; k++) ord[k] <= IW'(k);
      outer <= '0;
      inner <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
    end else if (start) begin
      outer <= (IW + 1)'(1);
      inner <= IW'(1);
      busy  <= 1'b1;
    end else if (busy) begin
      if (int'(outer) >= N_CAND) begin
        busy <= 1'b0;
        fin  <= 1'b1;
      end else if (swap_now) begin
        ord[inner]    <= id_lo;
        ord[inner_m1] <= id_hi;
        inner         <= inner_m1;
      end else begin
        outer <= outer + 1'b1;
        inner <= IW'(outer + 1'b1);
      end
    end
  end

endmodule

// File: rtl/evid_rank.sv
module evid_rank
  import evid_pkg::*;
#(
  parameter int N_OUT  = 4,
  parameter int N_CAND = 4,
  parameter int CNT_W  = 6,
  localparam int IW = (N_CAND > 1) ? $clog2(N_CAND) : 1,
  localparam int DW = $clog2(N_OUT + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pat_valid,
  input  logic                      pat_last,
  input  logic [IW-1:0]             cand_idx,
  input  logic [N_OUT-1:0]          dev_resp,
  input  logic [N_OUT-1:0]          fm_resp,
  input  logic [N_OUT-1:0]          exp_resp,
  output logic [N_CAND*CNT_W-1:0]   pred_tot,
  output logic [N_CAND*CNT_W-1:0]   mis_tot,
  output logic [N_CAND*CNT_W-1:0]   unx_tot,
  output logic [N_CAND*CNT_W-1:0]   cfl_tot,
  output logic [N_CAND*IW-1:0]      rank_list,
  output logic                      done
);

  phase_e                       ph;
  logic                         acc_en;
  logic                         sort_start;
  logic                         sort_fin;
  logic                         observ;
  logic                         dev_fail;
  logic [DW-1:0]                d_pred;
  logic [DW-1:0]                d_mis;
  logic [DW-1:0]                d_unx;
  logic [DW-1:0]                d_cfl;
  logic [N_CAND-1:0][CNT_W-1:0] pred_q;
  logic [N_CAND-1:0][CNT_W-1:0] mis_q;
  logic [N_CAND-1:0][CNT_W-1:0] unx_q;
  logic [N_CAND-1:0][CNT_W-1:0] cfl_q;
  logic [N_CAND-1:0][IW-1:0]    ord;

  assign acc_en     = (ph == PH_ACC) && pat_valid && (int'(cand_idx) < N_CAND);
  assign sort_start = (ph == PH_ACC) && pat_valid && pat_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_ACC;
    end else begin
      case (ph)
        PH_ACC:  if (sort_start) ph <= PH_SORT;
        PH_SORT: if (sort_fin) ph <= PH_FIN;
        default: ph <= PH_FIN;
      endcase
    end
  end

  evid_delta #(.N_OUT(N_OUT)) u_delta (
    .dev_resp (dev_resp),
    .fm_resp  (fm_resp),
    .exp_resp (exp_resp),
    .observ   (observ),
    .dev_fail (dev_fail),
    .d_pred   (d_pred),
    .d_mis    (d_mis),
    .d_unx    (d_unx),
    .d_cfl    (d_cfl)
  );

  evid_store #(.N_OUT(N_OUT), .N_CAND(N_CAND), .CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .observ   (observ),
    .cand_idx (cand_idx),
    .d_pred   (d_pred),
    .d_mis    (d_mis),
    .d_unx    (d_unx),
    .d_cfl    (d_cfl),
    .pred_q   (pred_q),
    .mis_q    (mis_q),
    .unx_q    (unx_q),
    .cfl_q    (cfl_q)
  );

  rank_sorter #(.N_CAND(N_CAND), .CNT_W(CNT_W)) u_sort (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (sort_start),
    .pred_q (pred_q),
    .mis_q  (mis_q),
    .cfl_q  (cfl_q),
    .ord    (ord),
    .fin    (sort_fin)
  );

  assign pred_tot  = pred_q;
  assign mis_tot   = mis_q;
  assign unx_tot   = unx_q;
  assign cfl_tot   = cfl_q;
  assign rank_list = ord;
  assign done      = sort_fin;

endmodule

// File: rtl/evid_rank_chk.sv
module evid_rank_chk
  import evid_pkg::*;
#(
  parameter int N_CAND = 4,
  parameter int CNT_W  = 6,
  localparam int IW = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    acc_en,
  input logic                    observ,
  input logic                    dev_fail,
  input logic [N_CAND*CNT_W-1:0] pred_tot,
  input logic [N_CAND*CNT_W-1:0] mis_tot,
  input logic [N_CAND*CNT_W-1:0] unx_tot,
  input logic [N_CAND*CNT_W-1:0] cfl_tot,
  input logic [N_CAND*IW-1:0]    rank_list,
  input logic                    done
);

  logic [CNT_W-1:0]  p_arr [N_CAND];
  logic [CNT_W-1:0]  m_arr [N_CAND];
  logic [CNT_W-1:0]  u_arr [N_CAND];
  logic [CNT_W-1:0]  c_arr [N_CAND];
  logic [N_CAND-1:0] seen;

  for (genvar k = 0; k < N_CAND; k++) begin : g_split
    assign p_arr[k] = pred_tot[k*CNT_W +: CNT_W];
    assign m_arr[k] = mis_tot[k*CNT_W +: CNT_W];
    assign u_arr[k] = unx_tot[k*CNT_W +: CNT_W];
    assign c_arr[k] = cfl_tot[k*CNT_W +: CNT_W];
  end

  always_comb begin
    seen = '0;
    for (int p = 0; p < N_CAND; p++) seen[rank_list[p*IW +: IW]] = 1'b1;
  end

  // R5
  unobs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en || !observ) |=> ($stable(pred_tot) && $stable(mis_tot) &&
                              $stable(unx_tot) && $stable(cfl_tot)));

  // R6
  pass_only_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && observ && !dev_fail) |=> ($stable(pred_tot) && $stable(unx_tot) &&
                                          $stable(cfl_tot)));

  // R11
  late_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(pred_tot) && $stable(mis_tot) && $stable(unx_tot) &&
              $stable(cfl_tot) && $stable(rank_list)));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R10
  perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&seen));

  for (genvar k = 0; k < N_CAND; k++) begin : g_tot
    // R4
    cfl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_arr[k] <= p_arr[k]) && (c_arr[k] <= m_arr[k]));

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((p_arr[k] >= $past(p_arr[k])) && (m_arr[k] >= $past(m_arr[k])) &&
                (u_arr[k] >= $past(u_arr[k])) && (c_arr[k] >= $past(c_arr[k]))));
  end

  for (genvar p = 0; p + 1 < N_CAND; p++) begin : g_ord
    logic [IW-1:0] a_id;
    logic [IW-1:0] b_id;
    logic          b_beats_a;
    logic          keys_eq;
    assign a_id      = rank_list[p*IW +: IW];
    assign b_id      = rank_list[(p+1)*IW +: IW];
    assign b_beats_a = ranks_ahead(32'(c_arr[b_id]), 32'(p_arr[b_id]), 32'(m_arr[b_id]),
                                   32'(c_arr[a_id]), 32'(p_arr[a_id]), 32'(m_arr[a_id]));
    assign keys_eq   = (c_arr[a_id] == c_arr[b_id]) && (p_arr[a_id] == p_arr[b_id]) &&
                       (m_arr[a_id] == m_arr[b_id]);

    // R8
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !b_beats_a);

    // R9
    tie_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && keys_eq) |-> (a_id < b_id));
  end

endmodule

bind evid_rank evid_rank_chk #(.N_CAND(N_CAND), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .observ    (observ),
  .dev_fail  (dev_fail),
  .pred_tot  (pred_tot),
  .mis_tot   (mis_tot),
  .unx_tot   (unx_tot),
  .cfl_tot   (cfl_tot),
  .rank_list (rank_list),
  .done      (done)
);

// File: tb/test_evid_rank.sv
module test_evid_rank;

  localparam int NO   = 4;
  localparam int NC   = 4;
  localparam int CW   = 6;
  localparam int IW   = 2;
  localparam int CAP  = 63;
  localparam time TCK = 10ns;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pat_valid;
  logic              pat_last;
  logic [IW-1:0]     cand_idx;
  logic [NO-1:0]     dev_resp;
  logic [NO-1:0]     fm_resp;
  logic [NO-1:0]     exp_resp;
  logic [NC*CW-1:0]  pred_tot;
  logic [NC*CW-1:0]  mis_tot;
  logic [NC*CW-1:0]  unx_tot;
  logic [NC*CW-1:0]  cfl_tot;
  logic [NC*IW-1:0]  rank_list;
  logic              done;

  int total = 0;
  int bad   = 0;
  int mp[NC];
  int mm[NC];
  int mu[NC];
  int mc[NC];
  logic [31:0] seed = 32'h1357_9bdf;

  always #(TCK/2) clk = ~clk;

  evid_rank #(.N_OUT(NO), .N_CAND(NC), .CNT_W(CW)) i_evid_rank (
    .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_last(pat_last),
    .cand_idx(cand_idx), .dev_resp(dev_resp), .fm_resp(fm_resp), .exp_resp(exp_resp),
    .pred_tot(pred_tot), .mis_tot(mis_tot), .unx_tot(unx_tot), .cfl_tot(cfl_tot),
    .rank_list(rank_list), .done(done)
  );

  function automatic int bitsum(input logic [NO-1:0] v);
    int n = 0;
    foreach (v[b]) if (v[b]) n++;
    return n;
  endfunction

  function automatic int capped(input int a);
    return (a > CAP) ? CAP : a;
  endfunction

  function automatic logic [NO-1:0] next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[19:16];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pat_valid = 1'b0; pat_last = 1'b0; cand_idx = '0;
    dev_resp = '0; fm_resp = '0; exp_resp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NC; k++) begin mp[k] = 0; mm[k] = 0; mu[k] = 0; mc[k] = 0; end
    @(negedge clk);
  endtask

  task automatic check_all(input string force_tag);
    for (int k = 0; k < NC; k++) begin
      chk((force_tag != "") ? force_tag : ((mp[k] == CAP) ? "R7" : "R1"),
          int'(pred_tot[k*CW +: CW]), mp[k]);
      chk((force_tag != "") ? force_tag : ((mm[k] == CAP) ? "R7" : "R2"),
          int'(mis_tot[k*CW +: CW]), mm[k]);
      chk((force_tag != "") ? force_tag : "R3", int'(unx_tot[k*CW +: CW]), mu[k]);
      chk((force_tag != "") ? force_tag : "R4", int'(cfl_tot[k*CW +: CW]), mc[k]);
    end
  endtask

  // One beat; the model is updated only when apply is set.
  task automatic beat(input int cand, input logic [NO-1:0] dv, input logic [NO-1:0] fm,
                      input logic [NO-1:0] ex, input logic last, input logic apply,
                      input string tag);
    logic [NO-1:0] dd;
    logic [NO-1:0] fd;
    int p;
    int m;
    string t;
    pat_valid = 1'b1; pat_last = last; cand_idx = IW'(cand);
    dev_resp = dv; fm_resp = fm; exp_resp = ex;
    dd = dv ^ ex;
    fd = fm ^ ex;
    if (apply && fd != '0) begin
      p = bitsum(dd & fd);
      m = bitsum(fd & ~dd);
      mp[cand] = capped(mp[cand] + p);
      mm[cand] = capped(mm[cand] + m);
      mu[cand] = capped(mu[cand] + bitsum(dd & ~fd));
      mc[cand] = capped(mc[cand] + ((p < m) ? p : m));
    end
    @(negedge clk);
    pat_valid = 1'b0; pat_last = 1'b0;
    t = tag;
    if (t == "" && fd == '0) t = "R5";
    else if (t == "" && dd == '0) t = "R6";
    if (t == "") check_all("");
    else check_all(t);
  endtask

  task automatic rank_check(input string tag);
    int  order[NC];
    bit  used[NC];
    int  best;
    int  waited = 0;
    while (!done && waited < 64) begin
      @(negedge clk);
      waited++;
    end
    chk("R10", int'(done), 1);
    for (int k = 0; k < NC; k++) used[k] = 1'b0;
    for (int pos = 0; pos < NC; pos++) begin
      best = -1;
      for (int k = 0; k < NC; k++) begin
        if (!used[k]) begin
          if (best < 0) best = k;
          else if (mc[k] < mc[best]) best = k;
          else if (mc[k] == mc[best] && mp[k] > mp[best]) best = k;
          else if (mc[k] == mc[best] && mp[k] == mp[best] && mm[k] < mm[best]) best = k;
        end
      end
      used[best] = 1'b1;
      order[pos] = best;
    end
    for (int pos = 0; pos < NC; pos++)
      chk(tag, int'(rank_list[pos*IW +: IW]), order[pos]);
    @(negedge clk);
    chk("R10", int'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NO-1:0] ex;
    do_reset();
    // R12: reset state
    check_all("R12");
    chk("R12", int'(done), 0);
    for (int pos = 0; pos < NC; pos++) chk("R12", int'(rank_list[pos*IW +: IW]), pos);

    // Sweep every device difference against every fault difference (R1..R6, R13, R8).
    for (int dsel = 0; dsel < 16; dsel++) begin
      do_reset();
      for (int f = 0; f < 16; f++) begin
        ex = next_rand();
        beat(f % NC, ex ^ NO'(dsel), ex ^ NO'(f), ex, f == 15, 1'b1, "");
        if (f < 15) chk("R10", int'(done), 0);
        // R13: other candidates checked inside check_all against untouched model.
      end
      rank_check("R8");
    end

    // Saturation (R7).
    do_reset();
    for (int n = 0; n < 20; n++) beat(0, 4'hF, 4'hF, 4'h0, 1'b0, 1'b1, "");
    for (int n = 0; n < 20; n++) beat(1, 4'h0, 4'hF, 4'h0, 1'b0, 1'b1, "");
    beat(2, 4'h3, 4'h1, 4'h0, 1'b1, 1'b1, "");
    chk("R7", int'(pred_tot[0 +: CW]), CAP);
    chk("R7", int'(mis_tot[CW +: CW]), CAP);
    rank_check("R8");

    // Ties fed in reverse index order (R9).
    do_reset();
    beat(3, 4'h1, 4'h3, 4'h0, 1'b0, 1'b1, "");
    beat(2, 4'h1, 4'h3, 4'h0, 1'b0, 1'b1, "");
    beat(1, 4'h1, 4'h3, 4'h0, 1'b0, 1'b1, "");
    beat(0, 4'h1, 4'h3, 4'h0, 1'b1, 1'b1, "");
    rank_check("R9");

    // Beats after the last strobe are ignored (R11).
    beat(2, 4'hF, 4'hF, 4'h0, 1'b0, 1'b0, "R11");
    beat(3, 4'h0, 4'hF, 4'h0, 1'b1, 1'b0, "R11");
    repeat (20) @(negedge clk);
    for (int pos = 0; pos < NC; pos++) chk("R11", int'(rank_list[pos*IW +: IW]), pos);
    check_all("R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule